// File: doc/BRIEF.md
# 16-bit Timer with Capture and Compare

The block holds a 16-bit up-counter and one capture/compare channel that shares it. The counter advances on one of two sources, picked by a select input: an internal tick that arrives once every four system clocks, or a rising edge on an external clock pin. The external pin passes through a two-flop synchroniser and an edge detector first. Either source then goes through a prescaler set to 1, 2, 4 or 8. When the count rolls over from FFFFh to 0000h, a sticky overflow flag is set.

A 4-bit mode input drives the channel's state machine. The machine has four states. ST_OFF covers modes 0000 to 0011. ST_CAP covers modes 01xx, where selected edges of a capture input latch the count. ST_CMP covers modes 10xx, where a 16-bit compare value is matched against the count. ST_PWM covers modes 11xx, which are parked and inactive. Each cycle the machine takes the transition that the mode field decodes to. When the mode value changes, an "entry" action runs: it clears the capture edge count and gives the compare pin its start level.

In the compare special-event mode, a match clears the shared counter and can emit a conversion-start strobe. Software is expected to switch the channel off before it loads a new capture prescaler.

Top module: `tcc_timer_unit`

## Requirements
- R1: After reset, count, cap_val, ovf_flag, ccp_flag, ccp_pin and adc_start are all 0.
- R2: With tmr_on=1, tmr_ext_sel=0 and tmr_psc=0, the count increments once every 4 clock cycles.
- R3: With tmr_ext_sel=1, each rising edge of ext_clk increments the count by one after a two-flop synchroniser. With tmr_on=0 the count does not change.
- R4: tmr_psc values 0, 1, 2 and 3 require 1, 2, 4 and 8 source ticks per increment. A cnt_wr pulse loads cnt_wdata and clears the prescaler phase.
- R5: An increment from FFFFh gives 0000h and sets ovf_flag. The flag stays set until ovf_clr.
- R6: Mode 0101 latches the count into cap_val on each rising edge of cap_in, and mode 0100 does so on each falling edge. Each capture sets ccp_flag, which stays set until ccp_flag_clr.
- R7: Mode 0110 captures on every 4th rising edge and mode 0111 on every 16th. Any change of mode value, including a pass through 0000, restarts the edge count.
- R8: A compare match is a cycle in which the count equals ccp_cmp_val but did not equal it in the previous cycle. Mode 1000 drives ccp_pin to 0 on entry and to 1 on a match. Mode 1001 drives ccp_pin to 1 on entry and to 0 on a match. Both modes set ccp_flag on a match.
- R9: In mode 1010, a match sets ccp_flag and ccp_pin holds its level.
- R10: In mode 1011, a match sets ccp_flag and clears the counter in the next cycle. It also pulses adc_start high for exactly one cycle, but only when adc_on=1.
- R11: Modes 0000 and 11xx capture nothing, set no flag and leave ccp_pin unchanged, even on matches and capture edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_on | input | 1 | Counter run enable |
| tmr_ext_sel | input | 1 | 1 = external clock edges, 0 = internal divide-by-4 tick |
| tmr_psc | input | 2 | Prescale select (1,2,4,8) |
| ext_clk | input | 1 | External count clock pin |
| cnt_wr | input | 1 | Load strobe for the counter |
| cnt_wdata | input | 16 | Value to load into the counter |
| ovf_clr | input | 1 | Clears the overflow flag |
| ccp_mode | input | 4 | Capture/compare mode field |
| ccp_cmp_val | input | 16 | Compare value |
| cap_in | input | 1 | Capture input pin |
| ccp_flag_clr | input | 1 | Clears the channel flag |
| adc_on | input | 1 | Converter enabled, gates adc_start |
| count | output | 16 | Current counter value |
| ovf_flag | output | 1 | Sticky rollover flag |
| cap_val | output | 16 | Last captured count |
| ccp_flag | output | 1 | Sticky capture/compare flag |
| ccp_pin | output | 1 | Compare output pin |
| adc_start | output | 1 | One-cycle conversion start strobe |

## Verification
The hardest case to reach is a restart of the capture prescaler in the middle of a count. The stimulus delivers three rising edges in every-4th mode, drops the mode to 0000 for a few cycles and returns to every-4th mode. Three more edges must then leave the flag clear, and only the fourth may set it. Capture tests run with the counter stopped at a loaded value, so the latched value is known exactly. Compare tests advance the count one external edge at a time, so the match cycle and the special-event clear can be checked to the edge.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
    typedef enum logic [1:0] {
        ST_OFF,
        ST_CAP,
        ST_CMP,
        ST_PWM
    } ccp_state_t;

    localparam logic [3:0] M_CAP_FALL = 4'b0100;
    localparam logic [3:0] M_CAP_RISE = 4'b0101;
    localparam logic [3:0] M_CAP_R4   = 4'b0110;
    localparam logic [3:0] M_CAP_R16  = 4'b0111;
    localparam logic [3:0] M_CMP_HI   = 4'b1000;
    localparam logic [3:0] M_CMP_LO   = 4'b1001;
    localparam logic [3:0] M_CMP_FLAG = 4'b1010;
    localparam logic [3:0] M_CMP_EVT  = 4'b1011;
endpackage

// File: rtl/tcc_edge_sync.sv
module tcc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] sh_q;
    logic            lvl;
    logic            prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], d};
    end

    assign lvl  = sh_q[STAGES-1];
    assign prev = sh_q[STAGES];
    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;
endmodule

// File: rtl/tcc_tick_gen.sv
module tcc_tick_gen #(
    parameter int DIV_W = 2,
    parameter int PSC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             ext_sel,
    input  logic             ext_rise,
    input  logic [PSC_W-1:0] psc,
    input  logic             pre_clr,
    output logic             step
);
    localparam int PC_W = (1 << PSC_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [PC_W-1:0]  pc_q;
    logic [PC_W-1:0]  limit;
    logic             int_tick;
    logic             src;
    logic             wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    assign int_tick = &div_q;
    assign src      = ext_sel ? ext_rise : int_tick;
    assign limit    = ~({PC_W{1'b1}} << psc);
    assign wrap     = (pc_q >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            pc_q <= '0;
        else if (pre_clr)      pc_q <= '0;
        else if (run && src)   pc_q <= wrap ? '0 : pc_q + 1'b1;
    end

    assign step = run && src && wrap && !pre_clr;
endmodule

// File: rtl/tcc_counter.sv
module tcc_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         clr,
    input  logic         ovf_clr,
    output logic [W-1:0] count,
    output logic         ovf_flag
);
    logic roll;

    assign roll = step && !wr && !clr && (&count);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    count <= '0;
        else if (wr)   count <= wdata;
        else if (clr)  count <= '0;
        else if (step) count <= count + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ovf_flag <= 1'b0;
        else if (roll)    ovf_flag <= 1'b1;
        else if (ovf_clr) ovf_flag <= 1'b0;
    end
endmodule

// File: rtl/tcc_ccp_fsm.sv
module tcc_ccp_fsm
    import tcc_pkg::*;
#(
    parameter int W     = 16,
    parameter int ECNT_W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   mode,
    input  logic [W-1:0] count,
    input  logic [W-1:0] cmp_val,
    input  logic         cap_rise,
    input  logic         cap_fall,
    input  logic         adc_on,
    input  logic         flag_clr,
    output logic         evt_clr,
    output logic         flag,
    output logic [W-1:0] cap_val,
    output logic         pin,
    output logic         adc_start
);
    localparam logic [ECNT_W-1:0] N4  = ECNT_W'(3);
    localparam logic [ECNT_W-1:0] N16 = ECNT_W'(15);

    ccp_state_t        state_q, state_d;
    logic [3:0]        mode_q;
    logic [ECNT_W-1:0] ecnt_q;
    logic              eq_q;
    logic              mode_chg;
    logic              qual;
    logic              hit;
    logic              eq;
    logic              cap_fire;
    logic              cmp_fire;

    // transition decode: the mode field picks the next state every cycle
    always_comb begin
        unique case (mode[3:2])
            2'b00:   state_d = ST_OFF;
            2'b01:   state_d = ST_CAP;
            2'b10:   state_d = ST_CMP;
            default: state_d = ST_PWM;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            mode_q  <= 4'b0000;
        end else begin
            state_q <= state_d;
            mode_q  <= mode;
        end
    end

    assign mode_chg = (mode != mode_q);
    assign eq       = (count == cmp_val);

    always_comb begin
        qual = (mode_q == M_CAP_FALL) ? cap_fall : cap_rise;
        unique case (mode_q[1:0])
            2'b10:   hit = (ecnt_q == N4);
            2'b11:   hit = (ecnt_q == N16);
            default: hit = 1'b1;
        endcase
        cap_fire = 1'b0;
        cmp_fire = 1'b0;
        unique case (state_q)
            ST_CAP:  cap_fire = qual && hit;
            ST_CMP:  cmp_fire = eq && !eq_q;
            default: ;
        endcase
    end

    assign evt_clr = cmp_fire && (mode_q == M_CMP_EVT);

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ecnt_q    <= '0;
            eq_q      <= 1'b0;
            flag      <= 1'b0;
            cap_val   <= '0;
            pin       <= 1'b0;
            adc_start <= 1'b0;
        end else begin
            eq_q      <= eq;
            adc_start <= evt_clr && adc_on;
            if (mode_chg || state_q != ST_CAP) ecnt_q <= '0;
            else if (qual)                     ecnt_q <= hit ? '0 : ecnt_q + 1'b1;
            if (cap_fire || cmp_fire) flag <= 1'b1;
            else if (flag_clr)        flag <= 1'b0;
            if (cap_fire) cap_val <= count;
            if (mode_chg) begin
                if (mode == M_CMP_HI)      pin <= 1'b0;
                else if (mode == M_CMP_LO) pin <= 1'b1;
            end else if (cmp_fire) begin
                if (mode_q == M_CMP_HI)      pin <= 1'b1;
                else if (mode_q == M_CMP_LO) pin <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tcc_timer_unit.sv
module tcc_timer_unit #(
    parameter int CNT_W = 16,
    parameter int PSC_W = 2,
    parameter int DIV_W = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmr_on,
    input  logic             tmr_ext_sel,
    input  logic [PSC_W-1:0] tmr_psc,
    input  logic             ext_clk,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             ovf_clr,
    input  logic [3:0]       ccp_mode,
    input  logic [CNT_W-1:0] ccp_cmp_val,
    input  logic             cap_in,
    input  logic             ccp_flag_clr,
    input  logic             adc_on,
    output logic [CNT_W-1:0] count,
    output logic             ovf_flag,
    output logic [CNT_W-1:0] cap_val,
    output logic             ccp_flag,
    output logic             ccp_pin,
    output logic             adc_start
);
    logic ext_rise, ext_fall_nc;
    logic cap_rise, cap_fall;
    logic step;
    logic evt_clr;

    tcc_edge_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
        .clk(clk), .rst_n(rst_n), .d(ext_clk), .rise(ext_rise), .fall(ext_fall_nc)
    );

    tcc_edge_sync #(.STAGES(SYNC_STAGES)) u_cap_sync (
        .clk(clk), .rst_n(rst_n), .d(cap_in), .rise(cap_rise), .fall(cap_fall)
    );

    tcc_tick_gen #(.DIV_W(DIV_W), .PSC_W(PSC_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(tmr_on), .ext_sel(tmr_ext_sel),
        .ext_rise(ext_rise), .psc(tmr_psc), .pre_clr(cnt_wr), .step(step)
    );

    tcc_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .step(step), .wr(cnt_wr), .wdata(cnt_wdata),
        .clr(evt_clr), .ovf_clr(ovf_clr), .count(count), .ovf_flag(ovf_flag)
    );

    tcc_ccp_fsm #(.W(CNT_W)) u_ccp (
        .clk(clk), .rst_n(rst_n), .mode(ccp_mode), .count(count),
        .cmp_val(ccp_cmp_val), .cap_rise(cap_rise), .cap_fall(cap_fall),
        .adc_on(adc_on), .flag_clr(ccp_flag_clr), .evt_clr(evt_clr),
        .flag(ccp_flag), .cap_val(cap_val), .pin(ccp_pin), .adc_start(adc_start)
    );
endmodule

// File: rtl/tcc_timer_chk.sv
module tcc_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tmr_on,
    input logic             cnt_wr,
    input logic [3:0]       ccp_mode,
    input logic             adc_on,
    input logic [CNT_W-1:0] count,
    input logic             ovf_flag,
    input logic             ccp_flag,
    input logic             adc_start
);
    AST_ADC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start); // R10

    AST_ADC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> $past(adc_on)); // R10

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(tmr_on) && !$past(cnt_wr) && $past(ccp_mode) != 4'b1011) |-> $stable(count)); // R3

    AST_ROLL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(count) == {CNT_W{1'b1}} && count == '0 && !$past(cnt_wr)
         && $past(ccp_mode) != 4'b1011) |-> ovf_flag); // R5

    AST_PWM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ccp_mode[3:2]) == 2'b11 && $past(ccp_mode[3:2], 2) == 2'b11) |-> !$rose(ccp_flag)); // R11
endmodule

bind tcc_timer_unit tcc_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tmr_on(tmr_on), .cnt_wr(cnt_wr),
    .ccp_mode(ccp_mode), .adc_on(adc_on), .count(count),
    .ovf_flag(ovf_flag), .ccp_flag(ccp_flag), .adc_start(adc_start)
);

// File: tb/sim_tcc_timer_unit.sv
module sim_tcc_timer_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tmr_on = 1'b0;
    logic        tmr_ext_sel = 1'b1;
    logic [1:0]  tmr_psc = 2'd0;
    logic        ext_clk = 1'b0;
    logic        cnt_wr = 1'b0;
    logic [15:0] cnt_wdata = 16'h0;
    logic        ovf_clr = 1'b0;
    logic [3:0]  ccp_mode = 4'b0000;
    logic [15:0] ccp_cmp_val = 16'h0012;
    logic        cap_in = 1'b0;
    logic        ccp_flag_clr = 1'b0;
    logic        adc_on = 1'b0;
    logic [15:0] count;
    logic        ovf_flag;
    logic [15:0] cap_val;
    logic        ccp_flag;
    logic        ccp_pin;
    logic        adc_start;

    int n_chk = 0;
    int n_bad = 0;
    int adc_pulses = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tcc_timer_unit u0 (.*);

    always @(negedge clk) if (adc_start) adc_pulses++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input logic [15:0] v);
        @(negedge clk); cnt_wr = 1'b1; cnt_wdata = v;
        @(negedge clk); cnt_wr = 1'b0;
    endtask

    task automatic ext_pulse(input int n);
        for (int i = 0; i < n; i++) begin
            ext_clk = 1'b1; cyc(5);
            ext_clk = 1'b0; cyc(5);
        end
    endtask

    task automatic cap_pulse(input int n);
        for (int i = 0; i < n; i++) begin
            cap_in = 1'b1; cyc(6);
            cap_in = 1'b0; cyc(6);
        end
    endtask

    task automatic clr_flag;
        @(negedge clk); ccp_flag_clr = 1'b1;
        @(negedge clk); ccp_flag_clr = 1'b0;
    endtask

    task automatic set_mode(input logic [3:0] m);
        @(negedge clk); ccp_mode = m; cyc(3);
    endtask

    task automatic t_reset;
        chk("R1 count", count, 0);
        chk("R1 ovf", ovf_flag, 0);
        chk("R1 capval", cap_val, 0);
        chk("R1 flag", ccp_flag, 0);
        chk("R1 pin", ccp_pin, 0);
        chk("R1 adc", adc_start, 0);
    endtask

    task automatic t_internal;
        tmr_ext_sel = 1'b0; tmr_psc = 2'd0;
        load(16'h0000);
        tmr_on = 1'b1; cyc(400); tmr_on = 1'b0; cyc(2);
        chk_rng("R2 div4 rate", int'(count), 99, 101);
        tmr_psc = 2'd1;
        load(16'h0000);
        tmr_on = 1'b1; cyc(400); tmr_on = 1'b0; cyc(2);
        chk_rng("R4 psc2 internal", int'(count), 49, 51);
        tmr_ext_sel = 1'b1; tmr_psc = 2'd0;
    endtask

    task automatic t_external;
        load(16'h0100);
        tmr_on = 1'b1;
        ext_pulse(5); cyc(4);
        chk("R3 ext edges", count, 16'h0105);
        tmr_on = 1'b0;
        ext_pulse(3); cyc(4);
        chk("R3 disabled hold", count, 16'h0105);
        tmr_on = 1'b1;
    endtask

    task automatic t_prescale;
        tmr_psc = 2'd2; load(16'h0000);
        ext_pulse(8); cyc(4);
        chk("R4 psc 1:4", count, 16'h0002);
        tmr_psc = 2'd3; load(16'h0000);
        ext_pulse(7); cyc(4);
        chk("R4 psc 1:8 partial", count, 16'h0000);
        ext_pulse(9); cyc(4);
        chk("R4 psc 1:8 full", count, 16'h0002);
        tmr_psc = 2'd0;
    endtask

    task automatic t_overflow;
        load(16'hFFFE);
        ext_pulse(1); cyc(4);
        chk("R5 no ovf yet", ovf_flag, 0);
        ext_pulse(1); cyc(4);
        chk("R5 rolled count", count, 16'h0000);
        chk("R5 ovf set", ovf_flag, 1);
        ext_pulse(1); cyc(4);
        chk("R5 ovf sticky", ovf_flag, 1);
        @(negedge clk); ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0; cyc(1);
        chk("R5 ovf cleared", ovf_flag, 0);
    endtask

    task automatic t_capture;
        tmr_on = 1'b0;
        load(16'h1234); clr_flag();
        set_mode(4'b0000);
        cap_pulse(2);
        chk("R11 off no flag", ccp_flag, 0);
        set_mode(4'b0101);
        cap_pulse(1);
        chk("R6 rise capval", cap_val, 16'h1234);
        chk("R6 rise flag", ccp_flag, 1);
        clr_flag(); load(16'h0ABC);
        set_mode(4'b0100);
        cap_in = 1'b1; cyc(6);
        chk("R6 fall ignores rise", ccp_flag, 0);
        cap_in = 1'b0; cyc(6);
        chk("R6 fall flag", ccp_flag, 1);
        chk("R6 fall capval", cap_val, 16'h0ABC);
        clr_flag(); set_mode(4'b0110);
        cap_pulse(3);
        chk("R7 every4 three", ccp_flag, 0);
        cap_pulse(1);
        chk("R7 every4 fourth", ccp_flag, 1);
        clr_flag(); set_mode(4'b0111);
        cap_pulse(15);
        chk("R7 every16 fifteen", ccp_flag, 0);
        cap_pulse(1);
        chk("R7 every16 sixteenth", ccp_flag, 1);
        clr_flag(); set_mode(4'b0110);
        cap_pulse(3);
        set_mode(4'b0000);
        set_mode(4'b0110);
        cap_pulse(3);
        chk("R7 restart after off", ccp_flag, 0);
        cap_pulse(1);
        chk("R7 restart fourth", ccp_flag, 1);
        clr_flag(); set_mode(4'b0000);
        tmr_on = 1'b1;
    endtask

    task automatic t_compare;
        ccp_cmp_val = 16'h0012;
        tmr_on = 1'b0; load(16'h0010); clr_flag();
        set_mode(4'b1000);
        chk("R8 hi entry pin", ccp_pin, 0);
        tmr_on = 1'b1;
        ext_pulse(2); cyc(3);
        chk("R8 hi match pin", ccp_pin, 1);
        chk("R8 hi match flag", ccp_flag, 1);
        clr_flag(); load(16'h0010);
        set_mode(4'b1010);
        ext_pulse(2); cyc(3);
        chk("R9 flag only flag", ccp_flag, 1);
        chk("R9 flag only pin held", ccp_pin, 1);
        clr_flag(); load(16'h0010);
        set_mode(4'b1001);
        chk("R8 lo entry pin", ccp_pin, 1);
        ext_pulse(2); cyc(3);
        chk("R8 lo match pin", ccp_pin, 0);
        chk("R8 lo match flag", ccp_flag, 1);
    endtask

    task automatic t_special;
        clr_flag(); load(16'h0010);
        adc_on = 1'b1; adc_pulses = 0;
        set_mode(4'b1011);
        ext_pulse(2); cyc(3);
        chk("R10 counter cleared", count, 16'h0000);
        chk("R10 flag", ccp_flag, 1);
        chk("R10 one adc pulse", adc_pulses, 1);
        clr_flag(); adc_on = 1'b0; load(16'h0010);
        ext_pulse(2); cyc(3);
        chk("R10 cleared no adc", count, 16'h0000);
        chk("R10 adc gated", adc_pulses, 1);
        clr_flag(); load(16'h0010);
        set_mode(4'b1100);
        ext_pulse(2); cyc(3);
        chk("R11 pwm no clear", count, 16'h0012);
        chk("R11 pwm no flag", ccp_flag, 0);
        chk("R11 pwm pin held", ccp_pin, 0);
    endtask

    initial begin
        cyc(3); rst_n = 1'b1; cyc(2);
        t_reset();
        t_internal();
        t_external();
        t_prescale();
        t_overflow();
        t_capture();
        t_compare();
        t_special();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule